// File: doc/BRIEF.md
# Pipelined Cascadable Parity Checker

This block checks the parity of a 12-bit data word when the parity bit for that word arrives one clock after the word itself. It registers the word so that the word lines up with its late parity bit. It then stores a pass/fail result in an error register one clock after the parity bit was sampled. The error line is active low and open drain. It is modelled as a pull-down request: a high value means the device pulls the shared error line low.

Used alone, the device takes a polarity select on its parity pin and checks either even or odd parity. Two devices can check a 24-bit word together. The upstream device exports the XOR of its own aligned 12 bits on its parity pin. The downstream device takes that partial sum in and folds it into its own check. The parity pin is split into an input, an output and an output-enable port, so its direction stays visible at the ports. Data bit 10 (the eleventh bit, counting from 0) also acts as the load enable for the error register. A global active-low output enable can release the error line.

Top module: `casc_parity_chk`

## Requirements
- R1: While `rst_n` is low, the error register and the aligned data register are cleared, so `err_drive_low` is 0 and `par_out` is 0.
- R2: `par_out` equals the XOR of all 12 bits of the `data_in` word sampled at the most recent clock edge.
- R3: `par_out_en` is 1 when `par_oe` is 0, which is cascade export. It is 0 when `par_oe` is 1, which means the parity pin is an input.
- R4: Even mode (`par_oe`=1, `par_io_in`=0): the stored result is an error when the XOR of the 12 aligned data bits and `par_in` is 1.
- R5: Odd mode (`par_oe`=1, `par_io_in`=1): the stored result is an error when the XOR of the 12 aligned data bits and `par_in` is 0.
- R6: Latency. A word sampled at edge k is checked against the `par_in` sampled at edge k+1. The result appears on `err_drive_low` right after edge k+1, and no earlier.
- R7: The result is loaded into the error register only when bit 10 of the aligned word is 1. When that bit is 0, the register keeps its previous value.
- R8: When `oe_n` is 1, `err_drive_low` is 0. The stored result is not lost, and it reappears when `oe_n` returns to 0.
- R9: Cascade (`par_oe`=1 and `par_io_in` taken from the upstream device's `par_out`): the downstream device flags an error when the XOR of the upstream word, its own word and its `par_in` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 12 | Data word; bit 10 also gates the error register load |
| par_in | input | 1 | Parity bit, one clock behind its word |
| par_oe | input | 1 | 0: export the partial sum; 1: the parity pin is an input |
| par_io_in | input | 1 | Parity pin input: polarity select, or the upstream partial sum |
| par_out | output | 1 | Parity pin output: XOR of the aligned word |
| par_out_en | output | 1 | Parity pin drive enable |
| oe_n | input | 1 | Active-low output enable for the error line |
| err_drive_low | output | 1 | 1 = pull the active-low error line low |

## Verification
The bench sweeps all 4096 words in even mode and in odd mode, and mixes correct and corrupted parity bits. A polarity inverted in the design would flag every good word. The bench also checks the error line in the cycle between a word and its parity bit. A design that skipped the alignment register would flag one cycle early or check the wrong word. Words whose bit 10 is clear must leave the previous flag in place, which catches an enable that is ignored or taken from the wrong bit or cycle. Two chained instances check 24-bit sums, which exposes a partial sum taken from unaligned data. Toggling `oe_n` shows that releasing the line does not clear the stored flag.

// File: rtl/casc_parity_chk.sv
module casc_parity_chk #(
  parameter int WIDTH  = 12,
  parameter int EN_BIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] data_in,
  input  logic             par_in,
  input  logic             par_oe,
  input  logic             par_io_in,
  output logic             par_out,
  output logic             par_out_en,
  input  logic             oe_n,
  output logic             err_drive_low
);

  logic [WIDTH-1:0] data_q;
  logic             err_q;
  logic             ref_bit;
  logic             err_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_in;
  end

  assign par_out    = ^data_q;
  assign par_out_en = ~par_oe;
  assign ref_bit    = par_oe & par_io_in;
  assign err_term   = par_out ^ par_in ^ ref_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              err_q <= 1'b0;
    else if (data_q[EN_BIT]) err_q <= err_term;
  end

  assign err_drive_low = err_q & ~oe_n;

endmodule

module casc_parity_chk_props #(
  parameter int WIDTH  = 12,
  parameter int EN_BIT = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] data_in,
  input logic             par_in,
  input logic             par_oe,
  input logic             par_io_in,
  input logic             par_out,
  input logic             oe_n,
  input logic             err_drive_low
);

  logic [1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen <= '0;
    else if (seen != 3) seen <= seen + 2'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!err_drive_low && !par_out));

  p_partial_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 1) |-> (par_out == $past(^data_in)));

  // R4, R5, R9 and the two-stage timing of R6
  p_check_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2 && !oe_n && $past(data_in[EN_BIT], 2)) |->
      (err_drive_low == ($past(^data_in, 2) ^ $past(par_in) ^ ($past(par_oe) & $past(par_io_in)))));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2 && !oe_n && !$past(oe_n) && !$past(data_in[EN_BIT], 2)) |-> $stable(err_drive_low));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !err_drive_low);

endmodule

bind casc_parity_chk casc_parity_chk_props #(.WIDTH(WIDTH), .EN_BIT(EN_BIT)) u_props (
  .clk(clk), .rst_n(rst_n), .data_in(data_in), .par_in(par_in), .par_oe(par_oe),
  .par_io_in(par_io_in), .par_out(par_out), .oe_n(oe_n), .err_drive_low(err_drive_low)
);

// File: tb/tb_casc_parity_chk.sv
`timescale 1ns/1ps
module tb_casc_parity_chk;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [11:0] d_dn = '0, d_up = '0;
  logic par_dn = 1'b0;
  logic pol = 1'b0, casc = 1'b0, oe_n = 1'b0;
  logic up_par_out, up_par_out_en, dn_par_out, dn_par_out_en;
  logic up_err, dn_err;
  logic dn_io_in;
  logic exp_err = 1'b0;
  int n_run = 0, n_fail = 0;

  assign dn_io_in = casc ? up_par_out : pol;

  casc_parity_chk u_up (
    .clk(clk), .rst_n(rst_n), .data_in(d_up), .par_in(1'b0), .par_oe(1'b0),
    .par_io_in(1'b0), .par_out(up_par_out), .par_out_en(up_par_out_en),
    .oe_n(1'b1), .err_drive_low(up_err));

  casc_parity_chk dut (
    .clk(clk), .rst_n(rst_n), .data_in(d_dn), .par_in(par_dn), .par_oe(1'b1),
    .par_io_in(dn_io_in), .par_out(dn_par_out), .par_out_en(dn_par_out_en),
    .oe_n(oe_n), .err_drive_low(dn_err));

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic xact(input logic [11:0] dn, input logic [11:0] up,
                      input logic par, input logic p, input logic c);
    logic term;
    @(negedge clk);
    d_dn = dn; d_up = up; pol = p; casc = c; par_dn = 1'b0;
    @(negedge clk);
    chk("R6 flag before parity edge", dn_err, exp_err);
    chk("R2 partial sum", dn_par_out, ^dn);
    if (c) chk("R9 upstream partial sum", up_par_out, ^up);
    par_dn = par; d_dn = '0; d_up = '0;
    term = (^dn) ^ par ^ (c ? ^up : p);
    if (dn[10]) exp_err = term;
    @(negedge clk);
    if (!dn[10])  chk("R7 hold when bit 10 clear", dn_err, exp_err);
    else if (c)   chk("R9 cascade check", dn_err, exp_err);
    else if (p)   chk("R5 odd check", dn_err, exp_err);
    else          chk("R4 even check", dn_err, exp_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    d_dn = 12'hFFF; d_up = 12'hFFF; par_dn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset err", dn_err, 1'b0);
    chk("R1 reset par_out", dn_par_out, 1'b0);
    chk("R1 reset up par_out", up_par_out, 1'b0);
    d_dn = '0; d_up = '0; par_dn = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 export drive on", up_par_out_en, 1'b1);
    chk("R3 import drive off", dn_par_out_en, 1'b0);

    for (int d = 0; d < 4096; d++) begin
      logic [11:0] w;
      w = 12'(d);
      xact(w, 12'h000, (^w) ^ w[3] ^ w[7], 1'b0, 1'b0);
    end
    for (int d = 0; d < 4096; d++) begin
      logic [11:0] w;
      w = 12'(d);
      xact(w, 12'h000, ~(^w) ^ w[2] ^ w[9], 1'b1, 1'b0);
    end
    for (int i = 0; i < 2048; i++) begin
      logic [11:0] a, b;
      a = 12'((i * 1103 + 5) & 4095);
      b = 12'((i * 2741 + 9) & 4095);
      xact(a, b, (^a) ^ (^b) ^ i[0] ^ i[4], 1'b0, 1'b1);
    end

    xact(12'h400, 12'h000, 1'b0, 1'b0, 1'b0);
    chk("R4 single-bit word wrong parity flags", dn_err, 1'b1);
    @(negedge clk);
    oe_n = 1'b1;
    #1 chk("R8 released while disabled", dn_err, 1'b0);
    repeat (2) @(negedge clk);
    chk("R8 still released", dn_err, 1'b0);
    oe_n = 1'b0;
    #1 chk("R8 stored flag reappears", dn_err, 1'b1);
    xact(12'h400, 12'h000, 1'b1, 1'b0, 1'b0);
    chk("R4 corrected word clears flag", dn_err, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule